// File: doc/BRIEF.md
# Per-Core Throttled Miss Status Register File

This block tracks the cache misses a shared last-level cache has sent to memory and are still outstanding. Each miss request carries the ID of the requesting core, a block address and a small request tag. A request to a block that no entry holds is a primary miss. It takes a free entry, but only if the requesting core still has room under its own cap. A request to a block that is already outstanding is a secondary miss. It is merged into the existing entry as a further waiting target, as long as a target slot is free.

Each core has a run-time cap on the number of entries its primary misses may hold. An allocation policy can lower a cap when a monitored metric, such as bus utilisation or an interference count, crosses a threshold. It can raise the cap again when performance feedback shows an excessive slowdown. A core that has reached its cap, or that finds no free entry, is reported as blocked. Its primary misses are refused until an entry retires.

When the fill for a block arrives, the block returns every waiting target, one per cycle and in arrival order. It then frees the entry and decrements the owning core's occupancy.

Top module: `core_throttled_mshr`

## Requirements
- R1: After reset every entry is free, every core's cap equals the entry count (8), `core_blocked` is all zero, `resp_valid` is 0, `fill_ready` is 1, and a primary miss from any core is ready.
- R2: A primary miss is accepted (`req_ready`=1) when its core's occupancy is below its cap and a free entry exists, and the accepted miss raises that core's occupancy by one.
- R3: A core whose occupancy has reached its cap has its `core_blocked` bit set and its primary misses refused, while other cores below their caps still allocate.
- R4: A secondary miss, from any core, merges into the matching entry while that entry holds fewer than 4 targets, and does not change any core's occupancy. With 4 targets already held, it is refused.
- R5: In the cycle after a fill for an outstanding block is accepted, `resp_valid` rises. The entry's targets then appear on `resp_core`/`resp_tag`, one per cycle, in the order they were accepted.
- R6: The entry is freed and its owner's occupancy drops in the same edge that retires its last target. In the next cycle a new miss can use the entry.
- R7: A cap write (`cap_we`, `cap_core`, `cap_val`) of 0 is stored as 1, and values above the entry count act as the entry count.
- R8: Lowering a cap below a core's current occupancy drops no in-flight entry. Every such entry still returns its targets on fill, and the core is not allowed to allocate until its occupancy falls below the new cap.
- R9: `fill_ready` is 0 while targets are being returned. A fill for a block that no entry holds is consumed and produces no response.
- R10: A miss to the block whose targets are currently being returned is refused.
- R11: When no entry is free, every core's `core_blocked` bit is set and primary misses are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_core | input | 2 | Requesting core ID |
| req_blk | input | 26 | Block address of the miss |
| req_tag | input | 6 | Request tag returned with the fill |
| req_ready | output | 1 | Request accepted this cycle (combinational) |
| core_blocked | output | 4 | Per-core: a primary miss from this core would be refused |
| fill_valid | input | 1 | Fill response for a block |
| fill_blk | input | 26 | Block address of the fill |
| fill_ready | output | 1 | Fill can be taken this cycle |
| resp_valid | output | 1 | A waiting target is being returned |
| resp_core | output | 2 | Core of the returned target |
| resp_tag | output | 6 | Tag of the returned target |
| cap_we | input | 1 | Write a core's cap |
| cap_core | input | 2 | Core whose cap is written |
| cap_val | input | 4 | New cap value (clamped to 1..8) |

## Verification
If a per-core occupancy counter drifts from the true entry ownership, the fault shows on `core_blocked` and `req_ready` in the cycle after the faulty edge. It does so for the first miss that probes the cap boundary, which is why the bench steps occupancy exactly to each cap. A corrupted target list or slot pointer appears on `resp_core`/`resp_tag` within one fill drain. A missed entry release shows up as a block stuck at all-cores-blocked after the pool has been filled and drained.

// File: rtl/tmshr_pkg.sv
`timescale 1ns/1ps
package tmshr_pkg;
    localparam int NCORE  = 4;
    localparam int NENT   = 8;
    localparam int NSLOT  = 4;
    localparam int ADDR_W = 26;
    localparam int TAG_W  = 6;

    localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int CNT_W  = $clog2(NSLOT + 1);
    localparam int OCC_W  = $clog2(NENT + 1);

    typedef logic [ADDR_W-1:0] blk_t;

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [TAG_W-1:0]  tag;
    } target_t;

    typedef struct packed {
        logic                   valid;
        blk_t                   blk;
        logic [CORE_W-1:0]      owner;
        logic [CNT_W-1:0]       n_tgt;
        target_t [NSLOT-1:0]    tgt;
    } entry_t;

    function automatic logic [OCC_W-1:0] clamp_cap(input logic [OCC_W-1:0] v);
        if (v == '0) return OCC_W'(1);
        if (v > OCC_W'(NENT)) return OCC_W'(NENT);
        return v;
    endfunction
endpackage

// File: rtl/tmshr_match.sv
`timescale 1ns/1ps
module tmshr_match import tmshr_pkg::*; (
    input  entry_t [NENT-1:0] ent_i,
    input  blk_t              key_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o
);
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int i = 0; i < NENT; i++) begin
            if (ent_i[i].valid && (ent_i[i].blk == key_i) && !hit_o) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tmshr_budget.sv
`timescale 1ns/1ps
module tmshr_budget import tmshr_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        inc_i,
    input  logic [CORE_W-1:0]           inc_core_i,
    input  logic                        dec_i,
    input  logic [CORE_W-1:0]           dec_core_i,
    input  logic                        cap_we_i,
    input  logic [CORE_W-1:0]           cap_core_i,
    input  logic [OCC_W-1:0]            cap_val_i,
    output logic [NCORE-1:0]            room_o,
    output logic [NCORE-1:0][OCC_W-1:0] occ_o,
    output logic [NCORE-1:0][OCC_W-1:0] cap_o
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic             add, sub;
        logic [OCC_W-1:0] occ_q, cap_q;

        assign add = inc_i && (inc_core_i == CORE_W'(c));
        assign sub = dec_i && (dec_core_i == CORE_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q <= '0;
                cap_q <= OCC_W'(NENT);
            end else begin
                occ_q <= occ_q + OCC_W'(add) - OCC_W'(sub);
                if (cap_we_i && (cap_core_i == CORE_W'(c)))
                    cap_q <= clamp_cap(cap_val_i);
            end
        end

        assign occ_o[c]  = occ_q;
        assign cap_o[c]  = cap_q;
        assign room_o[c] = occ_q < cap_q;
    end
endmodule

// File: rtl/tmshr_drain.sv
`timescale 1ns/1ps
module tmshr_drain import tmshr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  start_idx_i,
    input  logic [CNT_W-1:0]  n_tgt_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SLOT_W-1:0] slot_q;

    assign last_o = busy_q && ((CNT_W'(slot_q) + CNT_W'(1)) == n_tgt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            slot_q <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= start_idx_i;
            slot_q <= '0;
        end else if (busy_q) begin
            if (last_o) busy_q <= 1'b0;
            else        slot_q <= slot_q + SLOT_W'(1);
        end
    end

    assign busy_o = busy_q;
    assign idx_o  = idx_q;
    assign slot_o = slot_q;
endmodule

// File: rtl/core_throttled_mshr.sv
`timescale 1ns/1ps
module core_throttled_mshr import tmshr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_blk,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_ready,
    output logic [NCORE-1:0]  core_blocked,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_blk,
    output logic              fill_ready,
    output logic              resp_valid,
    output logic [CORE_W-1:0] resp_core,
    output logic [TAG_W-1:0]  resp_tag,
    input  logic              cap_we,
    input  logic [CORE_W-1:0] cap_core,
    input  logic [OCC_W-1:0]  cap_val
);
    entry_t [NENT-1:0]            ent_q;
    logic                         q_hit, f_hit, any_free;
    logic [IDX_W-1:0]             q_idx, f_idx, free_idx;
    logic [NCORE-1:0]             room;
    logic [NCORE-1:0][OCC_W-1:0]  occ, cap;
    logic                         drn_busy, drn_last;
    logic [IDX_W-1:0]             drn_idx;
    logic [SLOT_W-1:0]            drn_slot;
    entry_t                       hit_ent, drn_ent;
    logic                         merge_ok, alloc_ok, do_alloc, do_merge, do_start;
    target_t                      new_tgt;

    tmshr_match u_qmatch (.ent_i(ent_q), .key_i(req_blk),  .hit_o(q_hit), .hit_idx_o(q_idx));
    tmshr_match u_fmatch (.ent_i(ent_q), .key_i(fill_blk), .hit_o(f_hit), .hit_idx_o(f_idx));

    // lowest-index free entry
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NENT; i++) begin
            if (!ent_q[i].valid && !any_free) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign hit_ent = ent_q[q_idx];
    assign drn_ent = ent_q[drn_idx];

    assign merge_ok  = q_hit && !(drn_busy && (drn_idx == q_idx))
                     && (hit_ent.n_tgt < CNT_W'(NSLOT));
    assign alloc_ok  = !q_hit && room[req_core] && any_free;
    assign req_ready = merge_ok || alloc_ok;
    assign do_alloc  = req_valid && alloc_ok;
    assign do_merge  = req_valid && merge_ok;

    assign fill_ready = !drn_busy;
    assign do_start   = fill_valid && !drn_busy && f_hit;

    for (genvar c = 0; c < NCORE; c++) begin : g_blk
        assign core_blocked[c] = !room[c] || !any_free;
    end

    tmshr_budget u_budget (
        .clk(clk), .rst(rst),
        .inc_i(do_alloc), .inc_core_i(req_core),
        .dec_i(drn_last), .dec_core_i(drn_ent.owner),
        .cap_we_i(cap_we), .cap_core_i(cap_core), .cap_val_i(cap_val),
        .room_o(room), .occ_o(occ), .cap_o(cap)
    );

    tmshr_drain u_drain (
        .clk(clk), .rst(rst),
        .start_i(do_start), .start_idx_i(f_idx), .n_tgt_i(drn_ent.n_tgt),
        .busy_o(drn_busy), .idx_o(drn_idx), .slot_o(drn_slot), .last_o(drn_last)
    );

    assign resp_valid = drn_busy;
    assign resp_core  = drn_ent.tgt[drn_slot].core;
    assign resp_tag   = drn_ent.tgt[drn_slot].tag;

    assign new_tgt.core = req_core;
    assign new_tgt.tag  = req_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else begin
            if (do_alloc) begin
                ent_q[free_idx].valid  <= 1'b1;
                ent_q[free_idx].blk    <= req_blk;
                ent_q[free_idx].owner  <= req_core;
                ent_q[free_idx].n_tgt  <= CNT_W'(1);
                ent_q[free_idx].tgt[0] <= new_tgt;
            end
            if (do_merge) begin
                ent_q[q_idx].tgt[SLOT_W'(hit_ent.n_tgt)] <= new_tgt;
                ent_q[q_idx].n_tgt <= hit_ent.n_tgt + CNT_W'(1);
            end
            if (drn_last)
                ent_q[drn_idx].valid <= 1'b0;
        end
    end
endmodule

// File: rtl/tmshr_chk.sv
`timescale 1ns/1ps
module tmshr_chk import tmshr_pkg::*; (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic [CORE_W-1:0]           req_core,
    input logic                        req_ready,
    input logic                        q_hit,
    input logic [NCORE-1:0]            core_blocked,
    input logic                        fill_valid,
    input logic                        fill_ready,
    input logic                        f_hit,
    input logic                        resp_valid,
    input logic [NCORE-1:0][OCC_W-1:0] occ,
    input logic [NCORE-1:0][OCC_W-1:0] cap,
    input entry_t [NENT-1:0]           ent
);
    logic [OCC_W+3:0] occ_sum, vld_cnt;
    logic             cap_ok;

    always_comb begin
        occ_sum = '0;
        vld_cnt = '0;
        cap_ok  = 1'b1;
        for (int c = 0; c < NCORE; c++) begin
            occ_sum = occ_sum + (OCC_W+4)'(occ[c]);
            if ((cap[c] == '0) || (cap[c] > OCC_W'(NENT))) cap_ok = 1'b0;
        end
        for (int i = 0; i < NENT; i++)
            vld_cnt = vld_cnt + (OCC_W+4)'(ent[i].valid);
    end

    AST_BLOCKED_NO_PRIMARY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !q_hit && core_blocked[req_core]) |-> !req_ready); // R3

    AST_MERGE_NO_OCC_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && q_hit) |=> (occ_sum <= $past(occ_sum))); // R4

    AST_FILL_STARTS_RESP: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && f_hit) |=> resp_valid); // R5

    AST_OCC_MATCHES_ENTRIES: assert property (@(posedge clk) disable iff (rst)
        occ_sum == vld_cnt); // R6

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cap_ok); // R7

    AST_UNKNOWN_FILL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && !f_hit) |=> !resp_valid); // R9
endmodule

bind core_throttled_mshr tmshr_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
    .req_ready(req_ready), .q_hit(q_hit), .core_blocked(core_blocked),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .f_hit(f_hit),
    .resp_valid(resp_valid), .occ(occ), .cap(cap), .ent(ent_q)
);

// File: tb/core_throttled_mshr_tb_top.sv
`timescale 1ns/1ps
module core_throttled_mshr_tb_top;
    import tmshr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    localparam int    V_CORE [NV] = '{0, 1, 2, 3, 0, 1, 1};
    localparam int    V_BLK  [NV] = '{'h10, 'h10, 'h10, 'h10, 'h10, 'h20, 'h21};
    localparam int    V_TAG  [NV] = '{1, 2, 3, 4, 5, 6, 7};
    localparam int    V_EXP  [NV] = '{1, 1, 1, 1, 0, 1, 1};
    localparam string V_REQ  [NV] = '{"R2", "R4", "R4", "R4", "R4", "R2", "R2"};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [CORE_W-1:0] req_core = '0;
    logic [ADDR_W-1:0] req_blk = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              req_ready;
    logic [NCORE-1:0]  core_blocked;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_blk = '0;
    logic              fill_ready;
    logic              resp_valid;
    logic [CORE_W-1:0] resp_core;
    logic [TAG_W-1:0]  resp_tag;
    logic              cap_we = 1'b0;
    logic [CORE_W-1:0] cap_core = '0;
    logic [OCC_W-1:0]  cap_val = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_throttled_mshr dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_core(req_core),
        .req_blk(req_blk), .req_tag(req_tag), .req_ready(req_ready),
        .core_blocked(core_blocked), .fill_valid(fill_valid), .fill_blk(fill_blk),
        .fill_ready(fill_ready), .resp_valid(resp_valid), .resp_core(resp_core),
        .resp_tag(resp_tag), .cap_we(cap_we), .cap_core(cap_core), .cap_val(cap_val)
    );

    task automatic chk_eq(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // present a request for one cycle and check readiness before the edge
    task automatic req_step(input int core, input int blk, input int tag, input int exp, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_core  = CORE_W'(core);
        req_blk   = ADDR_W'(blk);
        req_tag   = TAG_W'(tag);
        #1 chk_eq(rq, int'(req_ready), exp);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // readiness probe that is withdrawn before any edge
    task automatic probe(input int core, input int blk, input int exp, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_core  = CORE_W'(core);
        req_blk   = ADDR_W'(blk);
        #1 chk_eq(rq, int'(req_ready), exp);
        req_valid = 1'b0;
    endtask

    task automatic cap_set(input int core, input int val);
        @(negedge clk);
        cap_we   = 1'b1;
        cap_core = CORE_W'(core);
        cap_val  = OCC_W'(val);
        @(posedge clk);
        #1 cap_we = 1'b0;
    endtask

    task automatic blk_chk(input int exp, input string rq);
        @(negedge clk);
        chk_eq(rq, int'(core_blocked), exp);
    endtask

    // fill a block; target k is expected as core c0+k*cstep, tag t0+k
    task automatic fill_check(input int blk, input int n, input int c0, input int cstep,
                              input int t0, input bit side, input string rq);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_blk   = ADDR_W'(blk);
        #1 chk_eq(rq, int'(fill_ready), 1);
        @(posedge clk);
        #1 fill_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_eq(rq, int'(resp_valid), 1);
            chk_eq(rq, int'(resp_core), c0 + k * cstep);
            chk_eq(rq, int'(resp_tag), t0 + k);
            if (side && k == 1) begin
                req_valid  = 1'b1;
                req_core   = '0;
                req_blk    = ADDR_W'(blk);
                fill_valid = 1'b1;
                fill_blk   = ADDR_W'('h3F);
                #1;
                chk_eq("R10", int'(req_ready), 0);
                chk_eq("R9", int'(fill_ready), 0);
                req_valid  = 1'b0;
                fill_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk_eq(rq, int'(resp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk_eq("R1", int'(core_blocked), 0);
        chk_eq("R1", int'(resp_valid), 0);
        chk_eq("R1", int'(fill_ready), 1);
        probe(3, 'h77, 1, "R1");

        // table: primary allocations and merging up to the slot limit
        for (int i = 0; i < NV; i++)
            req_step(V_CORE[i], V_BLK[i], V_TAG[i], V_EXP[i], V_REQ[i]);

        // R3: core1 holds 2 entries; cap of 2 blocks it, not the others
        cap_set(1, 2);
        blk_chk('b0010, "R3");
        probe(1, 'h22, 0, "R3");
        req_step(0, 'h30, 8, 1, "R3");

        // R7/R8: cap 0 is stored as 1; in-flight entries still fill
        cap_set(1, 0);
        fill_check('h20, 1, 1, 0, 6, 1'b0, "R8");
        blk_chk('b0010, "R8");
        fill_check('h21, 1, 1, 0, 7, 1'b0, "R8");
        blk_chk('b0000, "R7");

        // R5: four merged targets returned in arrival order, with R9/R10 side probes
        fill_check('h10, 4, 0, 1, 1, 1'b1, "R5");
        // R6: freed entry can be used again at once
        probe(3, 'h10, 1, "R6");

        // R9: fill to an absent block produces nothing
        @(negedge clk);
        fill_valid = 1'b1;
        fill_blk   = ADDR_W'('h3F);
        @(posedge clk);
        #1 fill_valid = 1'b0;
        @(negedge clk);
        chk_eq("R9", int'(resp_valid), 0);

        // R7: oversize cap acts as the full count
        cap_set(2, 15);
        req_step(2, 'h40, 9, 1, "R7");
        blk_chk('b0000, "R7");

        // R1 again after a mid-run reset
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", int'(core_blocked), 0);
        chk_eq("R1", int'(resp_valid), 0);
        probe(2, 'h10, 1, "R1");

        // R11: one core fills the whole pool
        for (int i = 0; i < NENT; i++)
            req_step(0, 'h100 + i, i, 1, "R2");
        blk_chk('b1111, "R11");
        probe(2, 'h200, 0, "R11");

        // R8: cap lowered below occupancy; nothing dropped
        cap_set(0, 3);
        fill_check('h100, 1, 0, 0, 0, 1'b0, "R8");
        blk_chk('b0001, "R8");
        probe(2, 'h200, 1, "R6");
        for (int i = 1; i < NENT; i++)
            fill_check('h100 + i, 1, 0, 0, i, 1'b0, "R8");
        blk_chk('b0000, "R8");
        for (int i = 0; i < 3; i++)
            req_step(0, 'h300 + i, i, 1, "R8");
        probe(0, 'h303, 0, "R8");
        blk_chk('b0001, "R3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule